// File: doc/BRIEF.md
# Time-Sync Target-Time Interrupt Controller

This block is the control and event logic for the hardware assist of a precision time protocol node. A host reaches it through a small register bus. The bus gives access to a 16-bit control word, a sticky event register, two 64-bit alarm (target-time) registers and a read-only view of the local time. The local time is a free-running seconds/nanoseconds counter. While an alarm channel is armed, its target time is compared for equality with the local time on every cycle. A match latches an event flag and disarms the channel. Transmit and receive timestamp-capture strobes latch flags of their own. Each flag reaches the single host interrupt line only when its own mask bit in the control word is set. A pulse-per-second output mirrors the second alarm flag when that output is enabled, and a mode output tells the ordinary-clock logic whether it is master or slave.

Each alarm channel is a two-state machine with the states CH_IDLE and CH_ARMED. Three transitions join them:
- arm: CH_IDLE to CH_ARMED, when the host writes the control word with the channel's arm bit set.
- host disarm: CH_ARMED to CH_IDLE, when the host writes the control word with the arm bit clear.
- hit: CH_ARMED to CH_IDLE, when the target equals the local time. A hit takes priority over a host write made in the same cycle.

The arm bit that reads back in the control word is this state. Writing a target register is never blocked, even while its channel is armed.

Top module: `tsync_tgt_irq`

## Requirements
- R1: After reset the control word, the event flags, both alarm targets and the local time are zero, and host_irq, pps_out and master_mode are low.
- R2: The control word is read and written at address 0. Bit 0 and bit 1 are the interrupt masks of alarms 1 and 2. Bits 2 and 3 are the event-1 and event-2 masks. Bits 4 and 5 arm alarms 1 and 2. Bit 6 enables the pulse output, bit 7 selects master mode, bit 8 is the transmit mask and bit 9 is the receive mask. Bits 15 to 10 and all higher bits read as zero.
- R3: While an alarm is armed, its target (seconds at address 2 or 4, nanoseconds at address 3 or 5) is compared for equality with the local time every cycle. At the clock edge that ends a matching cycle, the alarm's event flag is set and its arm bit is cleared.
- R4: An alarm flag raises host_irq only while that alarm's interrupt mask bit is set.
- R5: The event-1 and event-2 mask bits are storage only and never change host_irq.
- R6: pps_out equals the alarm-2 flag while the pulse-enable bit is set, and is low while it is clear.
- R7: A transmit strobe sets the transmit flag, which raises host_irq only while the transmit mask bit is set.
- R8: A receive strobe sets the receive flag, which raises host_irq only while the receive mask bit is set.
- R9: The event register at address 1 holds alarm 1 in bit 0, alarm 2 in bit 1, transmit in bit 2 and receive in bit 3. Its flags are sticky. Writing 1 to a bit clears only that bit. A set in the same cycle as a clear wins.
- R10: master_mode follows the master-mode bit of the control word.
- R11: A target register may be written while its alarm is armed, and the new value reads back and is used for the compare. Writing the control word with an arm bit clear disarms that alarm before it can match.
- R12: Every cycle the local time advances by NS_STEP nanoseconds. The nanosecond field wraps at NS_PER_SEC and the wrap adds one second. Seconds read at address 6 and nanoseconds at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | TW | Write data |
| reg_rdata | output | TW | Read data, combinational from reg_addr |
| tx_snap | input | 1 | Transmit timestamp-capture strobe |
| rx_snap | input | 1 | Receive timestamp-capture strobe |
| now_sec | output | TW | Local time, seconds |
| now_ns | output | TW | Local time, nanoseconds |
| host_irq | output | 1 | Host interrupt |
| pps_out | output | 1 | Pulse-per-second output |
| master_mode | output | 1 | Ordinary-clock master (1) or slave (0) |

## Verification
Some properties are checked on every cycle:
- a hit always disarms its channel and sets its flag on the next edge;
- an arm bit falls only after a hit or a host disarm;
- a flag falls only after a write-1 clear;
- the nanosecond field stays below its wrap value;
- with every mask clear, host_irq stays low and so do pps_out and master_mode outside their enables.

The exact cycle of each alarm hit, the mask-versus-flag combinations, the set-over-clear priority, target rewrites while armed and the seconds carry can only be shown by the bench's scenarios. The bench runs these against its behavioural model, which it compares on every clock.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 16;
    localparam int EVT_N  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_EVT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_T1S  = 3'd2;
    localparam logic [ADDR_W-1:0] A_T1N  = 3'd3;
    localparam logic [ADDR_W-1:0] A_T2S  = 3'd4;
    localparam logic [ADDR_W-1:0] A_T2N  = 3'd5;
    localparam logic [ADDR_W-1:0] A_NOWS = 3'd6;
    localparam logic [ADDR_W-1:0] A_NOWN = 3'd7;

    localparam int C_AM1  = 0;
    localparam int C_AM2  = 1;
    localparam int C_EM1  = 2;
    localparam int C_EM2  = 3;
    localparam int C_ARM1 = 4;
    localparam int C_ARM2 = 5;
    localparam int C_PPS  = 6;
    localparam int C_MST  = 7;
    localparam int C_TXM  = 8;
    localparam int C_RXM  = 9;
    localparam int C_USED = 10;

    localparam int E_HIT1 = 0;
    localparam int E_HIT2 = 1;
    localparam int E_TX   = 2;
    localparam int E_RX   = 3;

    typedef enum logic {CH_IDLE, CH_ARMED} ch_state_e;
endpackage

// File: rtl/tsa_systime.sv
module tsa_systime #(
    parameter int          TW         = 32,
    parameter int unsigned NS_STEP    = 5,
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] sec_q,
    output logic [TW-1:0] ns_q
);
    localparam logic [TW:0] STEP_W = (TW+1)'(NS_STEP);
    localparam logic [TW:0] LIM_W  = (TW+1)'(NS_PER_SEC);

    logic [TW:0] sum_w;

    always_comb sum_w = {1'b0, ns_q} + STEP_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else if (sum_w >= LIM_W) begin
            ns_q  <= TW'(sum_w - LIM_W);
            sec_q <= sec_q + 1'b1;
        end else begin
            ns_q  <= sum_w[TW-1:0];
        end
    end

    // R12: nanosecond field never reaches its wrap value
    a_r12_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, ns_q} < LIM_W);
endmodule

// File: rtl/tsa_alarm_ch.sv
module tsa_alarm_ch
    import tsa_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sec,
    input  logic          wr_ns,
    input  logic [TW-1:0] wdata,
    input  logic          ctl_wr,
    input  logic          ctl_arm,
    input  logic [TW-1:0] now_sec,
    input  logic [TW-1:0] now_ns,
    output logic          armed,
    output logic          hit,
    output logic [TW-1:0] tgt_sec,
    output logic [TW-1:0] tgt_ns
);
    ch_state_e state_q, state_d;
    logic      match_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_sec <= '0;
            tgt_ns  <= '0;
        end else begin
            if (wr_sec) tgt_sec <= wdata;
            if (wr_ns)  tgt_ns  <= wdata;
        end
    end

    always_comb begin
        match_w = (tgt_sec == now_sec) && (tgt_ns == now_ns);
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (ctl_wr && ctl_arm)   state_d = CH_ARMED;
            CH_ARMED: if (match_w)             state_d = CH_IDLE;
                      else if (ctl_wr && !ctl_arm) state_d = CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == CH_ARMED);
        hit   = armed && match_w;
    end

    // R3: a hit always leaves the channel idle
    a_r3_disarm_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !armed);
    // R11: the arm bit falls only after a hit or a host disarm
    a_r11_disarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> ($past(hit) || $past(ctl_wr && !ctl_arm)));
endmodule

// File: rtl/tsa_evt.sv
module tsa_evt #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              flags[i] <= 1'b0;
            else if (set[i])         flags[i] <= 1'b1;
            else if (clr_wr && clr_mask[i]) flags[i] <= 1'b0;
        end

        // R9: flags are sticky until a write-1 clear
        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(clr_wr && clr_mask[i]));
        // R9: a set is never lost to a same-cycle clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end
endmodule

// File: rtl/tsync_tgt_irq.sv
module tsync_tgt_irq
    import tsa_pkg::*;
#(
    parameter int          TW         = 32,
    parameter int unsigned NS_STEP    = 5,
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TW-1:0]     reg_wdata,
    output logic [TW-1:0]     reg_rdata,
    input  logic              tx_snap,
    input  logic              rx_snap,
    output logic [TW-1:0]     now_sec,
    output logic [TW-1:0]     now_ns,
    output logic              host_irq,
    output logic              pps_out,
    output logic              master_mode
);
    logic [C_USED-1:0] ctrl_q;
    logic [CTRL_W-1:0] ctrl_view;
    logic [EVT_N-1:0]  evt_q, evt_set;
    logic              wr_ctrl, wr_evt;
    logic [1:0]        armed, hit;
    logic [TW-1:0]     tgt_sec [2];
    logic [TW-1:0]     tgt_ns  [2];

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == A_CTRL);
        wr_evt  = reg_wr && (reg_addr == A_EVT);
    end

    tsa_systime #(.TW(TW), .NS_STEP(NS_STEP), .NS_PER_SEC(NS_PER_SEC)) u_time (
        .clk(clk), .rst_n(rst_n), .sec_q(now_sec), .ns_q(now_ns));

    for (genvar c = 0; c < 2; c++) begin : g_ch
        tsa_alarm_ch #(.TW(TW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sec  (reg_wr && (reg_addr == A_T1S + ADDR_W'(2*c))),
            .wr_ns   (reg_wr && (reg_addr == A_T1N + ADDR_W'(2*c))),
            .wdata   (reg_wdata),
            .ctl_wr  (wr_ctrl),
            .ctl_arm (reg_wdata[C_ARM1 + c]),
            .now_sec (now_sec),
            .now_ns  (now_ns),
            .armed   (armed[c]),
            .hit     (hit[c]),
            .tgt_sec (tgt_sec[c]),
            .tgt_ns  (tgt_ns[c]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr_ctrl) begin
            ctrl_q         <= reg_wdata[C_USED-1:0];
            ctrl_q[C_ARM1] <= 1'b0;
            ctrl_q[C_ARM2] <= 1'b0;
        end
    end

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[C_USED-1:0]  = ctrl_q;
        ctrl_view[C_ARM1]      = armed[0];
        ctrl_view[C_ARM2]      = armed[1];
        evt_set                = '0;
        evt_set[E_HIT1]        = hit[0];
        evt_set[E_HIT2]        = hit[1];
        evt_set[E_TX]          = tx_snap;
        evt_set[E_RX]          = rx_snap;
    end

    tsa_evt #(.N(EVT_N)) u_evt (
        .clk(clk), .rst_n(rst_n), .set(evt_set), .clr_wr(wr_evt),
        .clr_mask(reg_wdata[EVT_N-1:0]), .flags(evt_q));

    always_comb begin
        host_irq    = (evt_q[E_HIT1] && ctrl_q[C_AM1]) ||
                      (evt_q[E_HIT2] && ctrl_q[C_AM2]) ||
                      (evt_q[E_TX]   && ctrl_q[C_TXM]) ||
                      (evt_q[E_RX]   && ctrl_q[C_RXM]);
        pps_out     = ctrl_q[C_PPS] && evt_q[E_HIT2];
        master_mode = ctrl_q[C_MST];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_view;
            A_EVT:   reg_rdata[EVT_N-1:0]  = evt_q;
            A_T1S:   reg_rdata = tgt_sec[0];
            A_T1N:   reg_rdata = tgt_ns[0];
            A_T2S:   reg_rdata = tgt_sec[1];
            A_T2N:   reg_rdata = tgt_ns[1];
            A_NOWS:  reg_rdata = now_sec;
            default: reg_rdata = now_ns;
        endcase
    end

    // R3: a hit on either channel latches its flag on the next edge
    a_r3_hit1_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> evt_q[E_HIT1]);
    a_r3_hit2_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> evt_q[E_HIT2]);
    // R4 R5 R7 R8: with no flag mask set the interrupt stays low
    a_r5_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q[C_AM1] || ctrl_q[C_AM2] || ctrl_q[C_TXM] || ctrl_q[C_RXM]) |-> !host_irq);
    // R6: pulse output low while disabled, and only ever with the alarm-2 flag
    a_r6_pps_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_view[C_PPS] |-> !pps_out);
    a_r6_pps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pps_out |-> evt_q[E_HIT2]);
    // R10: mode output changes only after a control write
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(master_mode));
endmodule

// File: tb/tsync_tgt_irq_bench.sv
`timescale 1ns/1ps
module tsync_tgt_irq_bench;
    localparam int TW = 32;
    localparam int unsigned STEP = 5;
    localparam int unsigned LIM  = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [TW-1:0] reg_wdata = '0;
    logic [TW-1:0] reg_rdata;
    logic          tx_snap = 1'b0, rx_snap = 1'b0;
    logic [TW-1:0] now_sec, now_ns;
    logic          host_irq, pps_out, master_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tsync_tgt_irq #(.TW(TW), .NS_STEP(STEP), .NS_PER_SEC(LIM)) u_tsync_tgt_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_snap(tx_snap),
        .rx_snap(rx_snap), .now_sec(now_sec), .now_ns(now_ns),
        .host_irq(host_irq), .pps_out(pps_out), .master_mode(master_mode));

    // behavioural reference model
    logic [15:0]    m_ctrl = '0;
    logic [3:0]     m_evt  = '0;
    longint unsigned m_sec = 0, m_ns = 0;
    longint unsigned m_ts [2] = '{0, 0};
    longint unsigned m_tn [2] = '{0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_evt = '0; m_sec = 0; m_ns = 0;
            m_ts = '{0, 0}; m_tn = '{0, 0};
        end else begin
            bit h [2];
            bit wc, we;
            logic [15:0] nc;
            for (int c = 0; c < 2; c++)
                h[c] = m_ctrl[4+c] && (m_ts[c] == m_sec) && (m_tn[c] == m_ns);
            wc = reg_wr && reg_addr == 3'd0;
            we = reg_wr && reg_addr == 3'd1;
            nc = wc ? {6'd0, reg_wdata[9:0]} : m_ctrl;
            for (int c = 0; c < 2; c++) if (h[c]) nc[4+c] = 1'b0;
            m_evt = {rx_snap, tx_snap, h[1], h[0]} | (m_evt & ~(we ? reg_wdata[3:0] : 4'd0));
            m_ctrl = nc;
            for (int c = 0; c < 2; c++) begin
                if (reg_wr && reg_addr == 3'(2 + 2*c)) m_ts[c] = reg_wdata;
                if (reg_wr && reg_addr == 3'(3 + 2*c)) m_tn[c] = reg_wdata;
            end
            m_ns = m_ns + STEP;
            if (m_ns >= LIM) begin m_ns = m_ns - LIM; m_sec = m_sec + 1; end
        end
    end

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic ei;
            ei = (m_evt[0] & m_ctrl[0]) | (m_evt[1] & m_ctrl[1]) |
                 (m_evt[2] & m_ctrl[8]) | (m_evt[3] & m_ctrl[9]);
            check("R4 cycle host_irq", host_irq, ei);
            check("R6 cycle pps_out", pps_out, m_ctrl[6] & m_evt[1]);
            check("R10 cycle master_mode", master_mode, m_ctrl[7]);
            check("R12 cycle now_sec", now_sec, m_sec);
            check("R12 cycle now_ns", now_ns, m_ns);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [TW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [TW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_tx;
        @(negedge clk); tx_snap = 1'b1;
        @(negedge clk); tx_snap = 1'b0;
    endtask

    task automatic pulse_rx;
        @(negedge clk); rx_snap = 1'b1;
        @(negedge clk); rx_snap = 1'b0;
    endtask

    // program alarm c to fire d ns after the current time (d multiple of STEP)
    task automatic set_target(input int c, input int unsigned d);
        longint unsigned s, n;
        @(negedge clk);
        n = now_ns + d;
        s = now_sec + n / LIM;
        n = n % LIM;
        wr(3'(2 + 2*c), TW'(s));
        wr(3'(3 + 2*c), TW'(n));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, d); check("R1 ctrl after reset", d, 0);
        rd(3'd1, d); check("R1 events after reset", d, 0);
        rd(3'd2, d); check("R1 target1 sec after reset", d, 0);
        check("R1 host_irq after reset", host_irq, 0);
        check("R1 pps_out after reset", pps_out, 0);
        check("R1 master_mode after reset", master_mode, 0);

        // R2 control layout, upper bits read zero
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R2 ctrl readback", d, 32'h3FF);
        wr(3'd0, 32'h0000_000C);
        rd(3'd0, d); check("R2 ctrl event masks only", d, 32'hC);
        wr(3'd0, 0);

        // R12 time readable, carry into seconds
        repeat (250) @(negedge clk);
        rd(3'd6, d); check("R12 seconds carried", d, m_sec);
        check("R12 at least one second", (m_sec >= 1), 1);
        rd(3'd7, d); check("R12 ns readback", d, m_ns);

        // R3 R4 masked alarm 1 hit
        set_target(0, 300);
        wr(3'd0, 32'h11);
        repeat (80) @(negedge clk);
        rd(3'd1, d); check("R3 alarm1 flag set", d[0], 1);
        rd(3'd0, d); check("R3 alarm1 arm cleared", d[4], 0);
        check("R4 irq with alarm1 mask", host_irq, 1);
        wr(3'd1, 32'h1);
        rd(3'd1, d); check("R9 alarm1 flag cleared", d, 0);
        check("R9 irq drops after clear", host_irq, 0);

        // R4 unmasked alarm 2, R6 pulse
        set_target(1, 300);
        wr(3'd0, 32'h20);
        repeat (80) @(negedge clk);
        rd(3'd1, d); check("R3 alarm2 flag set", d[1], 1);
        check("R4 no irq without alarm2 mask", host_irq, 0);
        check("R6 pps low while disabled", pps_out, 0);
        wr(3'd0, 32'h40);
        check("R6 pps follows alarm2 flag", pps_out, 1);
        wr(3'd0, 32'h4C);
        check("R5 event masks give no irq", host_irq, 0);

        // R7 transmit flag and mask
        pulse_tx;
        rd(3'd1, d); check("R7 tx flag set", d[2], 1);
        check("R7 no irq without tx mask", host_irq, 0);
        wr(3'd0, 32'h14C);
        check("R7 irq with tx mask", host_irq, 1);
        wr(3'd1, 32'h2);
        check("R6 pps drops on alarm2 clear", pps_out, 0);
        rd(3'd1, d); check("R9 selective clear", d, 32'h4);

        // R9 set wins over clear
        @(negedge clk);
        tx_snap = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h4;
        @(negedge clk);
        tx_snap = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(3'd1, d); check("R9 set wins over clear", d[2], 1);

        // R8 receive flag and mask
        wr(3'd1, 32'hF);
        wr(3'd0, 32'h0);
        pulse_rx;
        rd(3'd1, d); check("R8 rx flag set", d, 32'h8);
        check("R8 no irq without rx mask", host_irq, 0);
        wr(3'd0, 32'h200);
        check("R8 irq with rx mask", host_irq, 1);
        wr(3'd1, 32'h8);

        // R10 mode output
        wr(3'd0, 32'h80);
        check("R10 master mode set", master_mode, 1);
        wr(3'd0, 32'h0);
        check("R10 slave mode", master_mode, 0);

        // R11 rewrite target while armed
        set_target(0, 5000);
        wr(3'd0, 32'h10);
        set_target(0, 200);
        rd(3'd3, d); check("R11 target rewrite readback", d, m_tn[0]);
        repeat (70) @(negedge clk);
        rd(3'd1, d); check("R11 rewritten target hits", d[0], 1);
        wr(3'd1, 32'h1);

        // R11 host disarm before match
        set_target(0, 300);
        wr(3'd0, 32'h10);
        wr(3'd0, 32'h0);
        repeat (80) @(negedge clk);
        rd(3'd1, d); check("R11 disarmed alarm silent", d[0], 0);

        repeat (5) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule